// File: doc/BRIEF.md
# Renaming Register File

This block holds the architectural integer registers of an out-of-order core together with the rename state for each one. Every register stores a data word, a producer tag and a ready flag. The producer tag is the reorder-buffer slot of the most recent in-flight writer. The ready flag shows that the stored value is final and no writer is pending.

The issue stage presents up to two source register indices and an optional destination index in one cycle. One cycle later the block returns, for each source that was requested, the value, the producer tag and the ready flag. The destination register is then marked as waiting on the issuing slot's tag.

The commit stage retires one result per cycle. The result value is always written into its register. The ready flag comes back only if no younger writer has claimed the register since. A commit in the same cycle as a read of the same register is forwarded into that read. When the fixed-zero option is set, register 0 is a constant zero: it is never busy and it ignores all writes.

Top module: `rename_regfile`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register takes value 0, tag 0 and ready 1. Both source outputs also take value 0, tag 0 and ready 1.
- R2: When `commit_valid` is high, `commit_value` is written into register `commit_idx` whatever the tags are. Register 0 is excepted when the fixed-zero option is set.
- R3: A commit sets the register's ready flag only when the register's stored tag equals `commit_tag`. On a mismatch the ready flag keeps its old value.
- R4: When `issue_valid` and `srcN_valid` are both high at an edge, `srcN_value`, `srcN_tag` and `srcN_ready` show the state of register `srcN_idx` from after the previous edge. They change at that same edge and are visible for the cycle that follows.
- R5: If a source read and a commit address the same register in one cycle, the read returns `commit_value` with tag 0 and ready 1. This holds even when the tags differ.
- R6: When `issue_valid` and `dst_valid` are high, register `dst_idx` takes tag `issue_tag` and its ready flag is cleared.
- R7: When a commit and a destination claim hit the same register in one cycle, the claim's tag and cleared ready flag win. The commit value is still written.
- R8: With the fixed-zero option set (the default), register 0 reads as value 0, tag 0, ready 1. Claims and commits to register 0 have no effect.
- R9: A source output keeps its value, tag and ready flag when `issue_valid` is low or its own `srcN_valid` is low.
- R10: A source read in the same cycle as a claim of that register returns the state from before the claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_valid | input | 1 | An instruction is issued this cycle |
| src1_valid | input | 1 | First source operand is requested |
| src1_idx | input | IDX_W (5) | First source register index |
| src2_valid | input | 1 | Second source operand is requested |
| src2_idx | input | IDX_W (5) | Second source register index |
| dst_valid | input | 1 | Issuing instruction writes a register |
| dst_idx | input | IDX_W (5) | Destination register index |
| issue_tag | input | TAG_W (5) | Reorder-buffer slot of the issuing instruction |
| commit_valid | input | 1 | A result retires this cycle |
| commit_idx | input | IDX_W (5) | Register the retiring result writes |
| commit_tag | input | TAG_W (5) | Reorder-buffer slot of the retiring instruction |
| commit_value | input | DATA_W (32) | Retiring result value |
| src1_value | output | DATA_W (32) | First source value |
| src1_tag | output | TAG_W (5) | First source producer tag |
| src1_ready | output | 1 | First source has no pending writer |
| src2_value | output | DATA_W (32) | Second source value |
| src2_tag | output | TAG_W (5) | Second source producer tag |
| src2_ready | output | 1 | Second source has no pending writer |

## Verification
All registers are swept through both read ports after reset, after a full round of commits with distinct values, and after a full round of claims with distinct tags. These sweeps separate correct indexing from aliasing, and stored state from reset state. Commits are then applied with mismatching tags and with matching tags, while the same register is read in the same cycle. This tells the tag-gated ready update apart from the unconditional value write and from the forwarding path. Further cycles combine a claim and a commit on one register and touch register 0. Idle cycles, and cycles with a source disabled, show that the outputs hold.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
   typedef enum logic [1:0] {
      RD_FROM_ARRAY  = 2'd0,
      RD_FROM_COMMIT = 2'd1,
      RD_FROM_ZERO   = 2'd2
   } rd_src_e;
endpackage

// File: rtl/rrf_onehot.sv
module rrf_onehot #(
   parameter int unsigned NUM_OUT = 32,
   parameter int unsigned IDX_W   = 5
) (
   input  logic               en,
   input  logic [IDX_W-1:0]   idx,
   output logic [NUM_OUT-1:0] hit
);
   if (NUM_OUT > (1 << IDX_W)) begin : g_bad_width
      $error("rrf_onehot: index too narrow for output count");
   end

   for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
      assign hit[i] = en && (idx == IDX_W'(i));
   end
endmodule

// File: rtl/rrf_entry.sv
module rrf_entry #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned TAG_W      = 5,
   parameter bit          FIXED_ZERO = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_hit,
   input  logic [DATA_W-1:0] commit_value,
   input  logic [TAG_W-1:0]  commit_tag,
   input  logic              claim_hit,
   input  logic [TAG_W-1:0]  claim_tag,
   output logic [DATA_W-1:0] value,
   output logic [TAG_W-1:0]  tag,
   output logic              ready
);
   if (FIXED_ZERO) begin : g_const
      logic unused_entry_inputs;
      assign unused_entry_inputs = ^{clk, rst_n, commit_hit, commit_value,
                                     commit_tag, claim_hit, claim_tag};
      assign value = '0;
      assign tag   = '0;
      assign ready = 1'b1;
   end else begin : g_store
      logic [DATA_W-1:0] value_q;
      logic [TAG_W-1:0]  tag_q;
      logic              ready_q;
      logic              tag_match;

      assign tag_match = (tag_q == commit_tag);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            value_q <= '0;
         end else if (commit_hit) begin
            value_q <= commit_value;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tag_q   <= '0;
            ready_q <= 1'b1;
         end else if (claim_hit) begin
            tag_q   <= claim_tag;
            ready_q <= 1'b0;
         end else if (commit_hit && tag_match) begin
            ready_q <= 1'b1;
         end
      end

      assign value = value_q;
      assign tag   = tag_q;
      assign ready = ready_q;
   end
endmodule

// File: rtl/rrf_read_port.sv
module rrf_read_port
   import rrf_pkg::*;
#(
   parameter int unsigned NUM_REGS   = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned TAG_W      = 5,
   parameter int unsigned IDX_W      = 5,
   parameter bit          FIXED_ZERO = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             rd_en,
   input  logic [IDX_W-1:0]                 rd_idx,
   input  logic [NUM_REGS-1:0][DATA_W-1:0]  arr_value,
   input  logic [NUM_REGS-1:0][TAG_W-1:0]   arr_tag,
   input  logic [NUM_REGS-1:0]              arr_ready,
   input  logic                             commit_valid,
   input  logic [IDX_W-1:0]                 commit_idx,
   input  logic [DATA_W-1:0]                commit_value,
   output logic [DATA_W-1:0]                q_value,
   output logic [TAG_W-1:0]                 q_tag,
   output logic                             q_ready
);
   rd_src_e           sel;
   logic [DATA_W-1:0] nxt_value;
   logic [TAG_W-1:0]  nxt_tag;
   logic              nxt_ready;
   logic              idx_in_range;

   assign idx_in_range = (32'(rd_idx) < NUM_REGS);

   always_comb begin
      if (FIXED_ZERO && (rd_idx == '0)) begin
         sel = RD_FROM_ZERO;
      end else if (commit_valid && (commit_idx == rd_idx)) begin
         sel = RD_FROM_COMMIT;
      end else begin
         sel = RD_FROM_ARRAY;
      end
   end

   always_comb begin
      nxt_value = '0;
      nxt_tag   = '0;
      nxt_ready = 1'b1;
      unique case (sel)
         RD_FROM_ZERO: begin
            nxt_value = '0;
            nxt_tag   = '0;
            nxt_ready = 1'b1;
         end
         RD_FROM_COMMIT: begin
            nxt_value = commit_value;
            nxt_tag   = '0;
            nxt_ready = 1'b1;
         end
         default: begin
            if (idx_in_range) begin
               nxt_value = arr_value[rd_idx];
               nxt_tag   = arr_tag[rd_idx];
               nxt_ready = arr_ready[rd_idx];
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_value <= '0;
         q_tag   <= '0;
         q_ready <= 1'b1;
      end else if (rd_en) begin
         q_value <= nxt_value;
         q_tag   <= nxt_tag;
         q_ready <= nxt_ready;
      end
   end
endmodule

// File: rtl/rename_regfile.sv
module rename_regfile #(
   parameter int unsigned NUM_REGS       = 32,
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned TAG_W          = 5,
   parameter int unsigned IDX_W          = $clog2(NUM_REGS),
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic              src1_valid,
   input  logic [IDX_W-1:0]  src1_idx,
   input  logic              src2_valid,
   input  logic [IDX_W-1:0]  src2_idx,
   input  logic              dst_valid,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [TAG_W-1:0]  issue_tag,
   input  logic              commit_valid,
   input  logic [IDX_W-1:0]  commit_idx,
   input  logic [TAG_W-1:0]  commit_tag,
   input  logic [DATA_W-1:0] commit_value,
   output logic [DATA_W-1:0] src1_value,
   output logic [TAG_W-1:0]  src1_tag,
   output logic              src1_ready,
   output logic [DATA_W-1:0] src2_value,
   output logic [TAG_W-1:0]  src2_tag,
   output logic              src2_ready
);
   localparam int unsigned NUM_PORTS = 2;

   if (NUM_REGS < 2) begin : g_chk_regs
      $error("rename_regfile: NUM_REGS must be at least 2");
   end
   if (IDX_W != $clog2(NUM_REGS)) begin : g_chk_idx
      $error("rename_regfile: IDX_W must equal clog2(NUM_REGS)");
   end
   if (DATA_W < 1 || TAG_W < 1) begin : g_chk_w
      $error("rename_regfile: widths must be positive");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] arr_value;
   logic [NUM_REGS-1:0][TAG_W-1:0]  arr_tag;
   logic [NUM_REGS-1:0]             arr_ready;
   logic [NUM_REGS-1:0]             commit_hit;
   logic [NUM_REGS-1:0]             claim_hit;

   rrf_onehot #(.NUM_OUT(NUM_REGS), .IDX_W(IDX_W)) u_commit_dec (
      .en  (commit_valid),
      .idx (commit_idx),
      .hit (commit_hit)
   );

   rrf_onehot #(.NUM_OUT(NUM_REGS), .IDX_W(IDX_W)) u_claim_dec (
      .en  (issue_valid && dst_valid),
      .idx (dst_idx),
      .hit (claim_hit)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      rrf_entry #(
         .DATA_W     (DATA_W),
         .TAG_W      (TAG_W),
         .FIXED_ZERO (ZERO_REG_FIXED && (r == 0))
      ) u_entry (
         .clk          (clk),
         .rst_n        (rst_n),
         .commit_hit   (commit_hit[r]),
         .commit_value (commit_value),
         .commit_tag   (commit_tag),
         .claim_hit    (claim_hit[r]),
         .claim_tag    (issue_tag),
         .value        (arr_value[r]),
         .tag          (arr_tag[r]),
         .ready        (arr_ready[r])
      );
   end

   logic [NUM_PORTS-1:0]             p_en;
   logic [NUM_PORTS-1:0][IDX_W-1:0]  p_idx;
   logic [NUM_PORTS-1:0][DATA_W-1:0] p_value;
   logic [NUM_PORTS-1:0][TAG_W-1:0]  p_tag;
   logic [NUM_PORTS-1:0]             p_ready;

   assign p_en[0]  = issue_valid && src1_valid;
   assign p_en[1]  = issue_valid && src2_valid;
   assign p_idx[0] = src1_idx;
   assign p_idx[1] = src2_idx;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      rrf_read_port #(
         .NUM_REGS   (NUM_REGS),
         .DATA_W     (DATA_W),
         .TAG_W      (TAG_W),
         .IDX_W      (IDX_W),
         .FIXED_ZERO (ZERO_REG_FIXED)
      ) u_rd (
         .clk          (clk),
         .rst_n        (rst_n),
         .rd_en        (p_en[p]),
         .rd_idx       (p_idx[p]),
         .arr_value    (arr_value),
         .arr_tag      (arr_tag),
         .arr_ready    (arr_ready),
         .commit_valid (commit_valid),
         .commit_idx   (commit_idx),
         .commit_value (commit_value),
         .q_value      (p_value[p]),
         .q_tag        (p_tag[p]),
         .q_ready      (p_ready[p])
      );
   end

   assign src1_value = p_value[0];
   assign src1_tag   = p_tag[0];
   assign src1_ready = p_ready[0];
   assign src2_value = p_value[1];
   assign src2_tag   = p_tag[1];
   assign src2_ready = p_ready[1];
endmodule

// File: rtl/rrf_checker.sv
module rrf_checker #(
   parameter int unsigned DATA_W         = 32,
   parameter int unsigned TAG_W          = 5,
   parameter int unsigned IDX_W          = 5,
   parameter bit          ZERO_REG_FIXED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_valid,
   input logic              src1_valid,
   input logic [IDX_W-1:0]  src1_idx,
   input logic              src2_valid,
   input logic [IDX_W-1:0]  src2_idx,
   input logic              dst_valid,
   input logic [IDX_W-1:0]  dst_idx,
   input logic [TAG_W-1:0]  issue_tag,
   input logic              commit_valid,
   input logic [IDX_W-1:0]  commit_idx,
   input logic [TAG_W-1:0]  commit_tag,
   input logic [DATA_W-1:0] commit_value,
   input logic [DATA_W-1:0] src1_value,
   input logic [TAG_W-1:0]  src1_tag,
   input logic              src1_ready,
   input logic [DATA_W-1:0] src2_value,
   input logic [TAG_W-1:0]  src2_tag,
   input logic              src2_ready
);
   logic             claim_q;
   logic [IDX_W-1:0] claim_idx_q;
   logic [TAG_W-1:0] claim_tag_q;
   logic             unused_chk;

   assign unused_chk = ^{commit_tag, src2_tag};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         claim_q     <= 1'b0;
         claim_idx_q <= '0;
         claim_tag_q <= '0;
      end else begin
         claim_q     <= issue_valid && dst_valid && !(ZERO_REG_FIXED && dst_idx == '0);
         claim_idx_q <= dst_idx;
         claim_tag_q <= issue_tag;
      end
   end

   AST_HOLD_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_valid && src1_valid) |=> ($stable(src1_value) && $stable(src1_tag) && $stable(src1_ready))); // R9

   AST_HOLD_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
      !(issue_valid && src2_valid) |=> ($stable(src2_value) && $stable(src2_tag) && $stable(src2_ready))); // R9

   AST_FORWARD_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && src1_valid && commit_valid && commit_idx == src1_idx && !(ZERO_REG_FIXED && src1_idx == '0))
      |=> (src1_value == $past(commit_value) && src1_tag == '0 && src1_ready)); // R5

   AST_FORWARD_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && src2_valid && commit_valid && commit_idx == src2_idx && !(ZERO_REG_FIXED && src2_idx == '0))
      |=> (src2_value == $past(commit_value) && src2_ready)); // R5

   AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_REG_FIXED && issue_valid && src1_valid && src1_idx == '0)
      |=> (src1_value == '0 && src1_tag == '0 && src1_ready)); // R8

   AST_CLAIM_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_q && issue_valid && src1_valid && src1_idx == claim_idx_q &&
       !(commit_valid && commit_idx == src1_idx))
      |=> (!src1_ready && src1_tag == $past(claim_tag_q))); // R6
endmodule

bind rename_regfile rrf_checker #(
   .DATA_W         (DATA_W),
   .TAG_W          (TAG_W),
   .IDX_W          (IDX_W),
   .ZERO_REG_FIXED (ZERO_REG_FIXED)
) u_rrf_checker (.*);

// File: tb/rename_regfile_tb.sv
module rename_regfile_tb;
   localparam int NR = 32;
   localparam int DW = 32;
   localparam int TW = 5;
   localparam int IW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 0, src1_valid = 0, src2_valid = 0, dst_valid = 0;
   logic [IW-1:0] src1_idx = 0, src2_idx = 0, dst_idx = 0, commit_idx = 0;
   logic [TW-1:0] issue_tag = 0, commit_tag = 0;
   logic          commit_valid = 0;
   logic [DW-1:0] commit_value = 0;
   logic [DW-1:0] src1_value, src2_value;
   logic [TW-1:0] src1_tag, src2_tag;
   logic          src1_ready, src2_ready;

   rename_regfile u_dut (.*);

   always #10 clk = ~clk;

   int errors = 0;
   int checks = 0;
   string cur_req = "R1";
   bit done = 0;

   logic [DW-1:0] m_val [NR];
   logic [TW-1:0] m_tag [NR];
   logic          m_rdy [NR];
   logic [DW+TW:0] e1, e2;

   function automatic logic [DW+TW:0] model_read(input logic [IW-1:0] idx);
      if (idx == 0) return {{DW{1'b0}}, {TW{1'b0}}, 1'b1};
      if (commit_valid && commit_idx == idx) return {commit_value, {TW{1'b0}}, 1'b1};
      return {m_val[idx], m_tag[idx], m_rdy[idx]};
   endfunction

   task automatic check(input string port, input logic [DW+TW:0] got, input logic [DW+TW:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got v=%h t=%0d r=%0b exp v=%h t=%0d r=%0b", cur_req, port,
                  got[DW+TW:TW+1], got[TW:1], got[0], exp[DW+TW:TW+1], exp[TW:1], exp[0]);
      end
   endtask

   task automatic idle();
      issue_valid = 0; src1_valid = 0; src2_valid = 0; dst_valid = 0; commit_valid = 0;
   endtask

   task automatic cyc(input bit do_check);
      if (issue_valid && src1_valid) e1 = model_read(src1_idx);
      if (issue_valid && src2_valid) e2 = model_read(src2_idx);
      @(posedge clk);
      if (commit_valid && commit_idx != 0) begin
         m_val[commit_idx] = commit_value;
         if (m_tag[commit_idx] == commit_tag) m_rdy[commit_idx] = 1'b1;
      end
      if (issue_valid && dst_valid && dst_idx != 0) begin
         m_tag[dst_idx] = issue_tag;
         m_rdy[dst_idx] = 1'b0;
      end
      @(negedge clk);
      if (do_check) begin
         check("src1", {src1_value, src1_tag, src1_ready}, e1);
         check("src2", {src2_value, src2_tag, src2_ready}, e2);
      end
   endtask

   task automatic rd(input int a, input int b);
      issue_valid = 1; src1_valid = 1; src2_valid = 1;
      src1_idx = IW'(a); src2_idx = IW'(b);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NR; i++) begin m_val[i] = 0; m_tag[i] = 0; m_rdy[i] = 1; end
      e1 = {{DW{1'b0}}, {TW{1'b0}}, 1'b1};
      e2 = e1;
      repeat (3) @(negedge clk);
      cur_req = "R1";
      check("src1", {src1_value, src1_tag, src1_ready}, e1);
      check("src2", {src2_value, src2_tag, src2_ready}, e2);
      rst_n = 1;
      // R1 / R4: sweep reset contents through both ports
      for (int i = 0; i < NR; i++) begin
         idle(); rd(i, NR - 1 - i); cyc(1);
      end
      // R2: commit distinct values to every register, read back one cycle later
      cur_req = "R2";
      for (int i = 0; i < NR; i++) begin
         idle(); commit_valid = 1; commit_idx = IW'(i);
         commit_value = DW'(i) * 32'h9E37_79B9 + 32'h1234;
         commit_tag = TW'(i + 3);
         cyc(0);
      end
      cur_req = "R4";
      for (int i = 0; i < NR; i++) begin
         idle(); rd(i, (i * 5) % NR); cyc(1);
      end
      // R6 / R10: claim each register, src1 reads the previous claim, src2 the same-cycle one
      cur_req = "R6";
      for (int i = 1; i < NR; i++) begin
         idle(); rd(i - 1, i);
         dst_valid = 1; dst_idx = IW'(i); issue_tag = TW'((i * 7) % NR);
         cyc(1);
      end
      cur_req = "R10";
      idle(); issue_valid = 1; src1_valid = 1; src1_idx = 5;
      dst_valid = 1; dst_idx = 5; issue_tag = 5'd17; cyc(1);
      cur_req = "R6";
      idle(); rd(5, 31); cyc(1);
      // R3: mismatched tags write the value but leave the register busy
      cur_req = "R3";
      for (int i = 1; i < NR; i++) begin
         idle(); commit_valid = 1; commit_idx = IW'(i);
         commit_value = 32'hA5A5_0000 | DW'(i);
         commit_tag = m_tag[i] + 1'b1;
         cyc(0);
      end
      for (int i = 1; i < NR; i++) begin
         idle(); rd(i, (i + 1) % NR); cyc(1);
      end
      // R5 / R3: matching commits, src1 sees the forward, src2 the previous register
      cur_req = "R5";
      for (int i = 1; i < NR; i++) begin
         idle(); rd(i, i - 1);
         commit_valid = 1; commit_idx = IW'(i);
         commit_value = 32'h5A00_0000 + DW'(i * 3);
         commit_tag = m_tag[i];
         cyc(1);
      end
      cur_req = "R3";
      for (int i = 1; i < NR; i++) begin
         idle(); rd(i, NR - i); cyc(1);
      end
      // R5: forward even when the tag mismatches a busy register
      cur_req = "R5";
      idle(); dst_valid = 1; issue_valid = 1; dst_idx = 9; issue_tag = 5'd2; cyc(0);
      idle(); rd(9, 9); commit_valid = 1; commit_idx = 9; commit_tag = 5'd3;
      commit_value = 32'hDEAD_BEEF; cyc(1);
      idle(); rd(9, 0); cyc(1);
      // R7: claim and matching commit on the same register in one cycle
      cur_req = "R7";
      idle(); issue_valid = 1; dst_valid = 1; dst_idx = 12; issue_tag = 5'd20;
      commit_valid = 1; commit_idx = 12; commit_tag = m_tag[12];
      commit_value = 32'h0C0C_0C0C; cyc(0);
      idle(); rd(12, 12); cyc(1);
      // R8: register 0 ignores claims and commits
      cur_req = "R8";
      idle(); issue_valid = 1; dst_valid = 1; dst_idx = 0; issue_tag = 5'd9;
      commit_valid = 1; commit_idx = 0; commit_tag = 5'd0; commit_value = 32'hFFFF_FFFF;
      src1_valid = 1; src1_idx = 0; cyc(1);
      idle(); rd(0, 0); cyc(1);
      // R9: outputs hold when idle or a source is disabled
      cur_req = "R9";
      idle(); rd(12, 9); cyc(1);
      idle(); commit_valid = 1; commit_idx = 12; commit_tag = 5'd20;
      commit_value = 32'h7777_7777; cyc(1);
      idle(); src1_valid = 1; src1_idx = 3; src2_valid = 1; src2_idx = 4; cyc(1);
      idle(); issue_valid = 1; src2_valid = 1; src2_idx = 12; src1_idx = 3; cyc(1);
      idle(); repeat (2) cyc(1);
      finish_run();
   end
endmodule